// File: doc/BRIEF.md
# Dual-Channel Eye Margin Scanner

This block measures how much room a receiver's sampling point has before bit errors appear. Two decision channels sample the same incoming stream. The main channel stays at the chosen operating point near the centre of the eye. A second channel is moved around that point. The block needs no known test pattern. Any bit where the two channels disagree counts as an error.

After a start request, the block captures the centre voltage and phase codes. A sequencer then walks the scanning channel through a fixed list of positions. It first sweeps every voltage code from the lowest slicing level to the highest, with the phase held at the centre. It then sweeps every phase code, with the voltage held at the centre. At each position it waits a programmable settle time and then counts disagreements over a programmable gate window. It stores the count in a result array indexed by position number. Software reads the array through a read port and builds an equal-error contour from it.

Top module: `mscan_top`

## Requirements
- R1: Reset state. While `rst_n` is low, and until the first accepted start, `busy` and `done` are 0, both scan codes are 0, and every result entry reads 0.
- R2: Starting a scan. While idle, a high `start` sampled on a clock edge begins a scan, and `busy` is 1 from the next cycle. `ctr_vcode` and `ctr_pcode` are captured at that same edge.
- R3: Position order. Positions 0 to 2^VW-1 drive `scan_vcode` equal to the position number, in ascending order, with `scan_pcode` at the captured centre phase. Positions 2^VW to 2^VW+2^PW-1 then drive `scan_pcode` equal to the position minus 2^VW, in ascending order, with `scan_vcode` at the captured centre voltage.
- R4: Settle time. After each code change, the block spends `settle_len`+1 cycles without counting before its gate window opens.
- R5: Gate window. The gate window lasts `gate_len`+1 cycles. The stored count is the number of those cycles in which `main_bit` differs from `scan_bit`.
- R6: Saturation. A count saturates at 2^CW-1 and never wraps.
- R7: Result storage. The count for position k is written to entry k. `rd_count` returns entry `rd_idx` in the same cycle, and returns 0 for an index of 2^VW+2^PW or above. Entries keep their values until the next scan overwrites them.
- R8: End of scan. `done` is high for exactly one cycle, the cycle after the last gate cycle. `busy` is low in that cycle, and all results are already readable.
- R9: Start during a scan. A `start` sampled while `busy` is 1 has no effect on the codes, the results or the timing. A `start` sampled in the `done` cycle begins a new scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Scan request, honoured only while idle |
| main_bit | input | 1 | Bit decided by the main channel |
| scan_bit | input | 1 | Bit decided by the scanning channel |
| ctr_vcode | input | VW | Operating-point voltage code |
| ctr_pcode | input | PW | Operating-point phase code |
| gate_len | input | GW | Gate window minus one, in bit clocks |
| settle_len | input | SW | Settle delay minus one, in bit clocks |
| rd_idx | input | IW | Result index to read |
| scan_vcode | output | VW | Voltage code for the scanning slicer |
| scan_pcode | output | PW | Phase code for the scanning clock |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle end-of-scan pulse |
| rd_count | output | CW | Stored mismatch count at `rd_idx` |

## Verification
Two events can fall close together: the end of a scan and a new start request. In the worst case, `start` is held high across both the final gate cycle and the following `done` cycle. The first sample lands while the block is busy and must be ignored. The second sample lands in the idle `done` cycle and must start a fresh scan with the newly captured centre codes. A behavioural model in the bench predicts `busy`, `done` and both codes on every clock. After each scan, the bench reads back all stored counts, so a lost final write or a mistimed restart shows up at the ports.

// File: rtl/mscan_pkg.sv
package mscan_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SETTLE = 2'd1,
      ST_GATE   = 2'd2
   } mscan_st_e;
endpackage

// File: rtl/mscan_seq.sv
module mscan_seq
   import mscan_pkg::*;
#(
   parameter int VW   = 4,
   parameter int PW   = 3,
   parameter int GW   = 8,
   parameter int SW   = 4,
   parameter int NV   = 16,
   parameter int NPOS = 24,
   parameter int IW   = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [VW-1:0] ctr_vcode,
   input  logic [PW-1:0] ctr_pcode,
   input  logic [GW-1:0] gate_len,
   input  logic [SW-1:0] settle_len,
   output mscan_st_e     state,
   output logic [IW-1:0] pos,
   output logic          last_gate,
   output logic [VW-1:0] vcode,
   output logic [PW-1:0] pcode,
   output logic          done
);
   localparam logic [IW-1:0] LAST_POS = IW'(NPOS - 1);
   localparam logic [IW-1:0] NV_I     = IW'(NV);

   logic [SW-1:0] settle_cnt;
   logic [GW-1:0] gate_cnt;
   logic [VW-1:0] cv_q;
   logic [PW-1:0] cp_q;
   logic [IW-1:0] npos;
   logic [VW-1:0] nv;
   logic [PW-1:0] np;
   logic          idle;

   assign idle      = (state == ST_IDLE);
   assign last_gate = (state == ST_GATE) && (gate_cnt == '0);

   // codes for the next position to visit
   always_comb begin
      npos = idle ? '0 : pos + 1'b1;
      if (npos < NV_I) begin
         nv = npos[VW-1:0];
         np = idle ? ctr_pcode : cp_q;
      end else begin
         nv = idle ? ctr_vcode : cv_q;
         np = PW'(npos - NV_I);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         pos        <= '0;
         settle_cnt <= '0;
         gate_cnt   <= '0;
         cv_q       <= '0;
         cp_q       <= '0;
         vcode      <= '0;
         pcode      <= '0;
         done       <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  cv_q       <= ctr_vcode;
                  cp_q       <= ctr_pcode;
                  pos        <= npos;
                  vcode      <= nv;
                  pcode      <= np;
                  settle_cnt <= settle_len;
                  state      <= ST_SETTLE;
               end
            end
            ST_SETTLE: begin
               if (settle_cnt == '0) begin
                  gate_cnt <= gate_len;
                  state    <= ST_GATE;
               end else begin
                  settle_cnt <= settle_cnt - 1'b1;
               end
            end
            ST_GATE: begin
               if (gate_cnt == '0) begin
                  if (pos == LAST_POS) begin
                     state <= ST_IDLE;
                     done  <= 1'b1;
                  end else begin
                     pos        <= npos;
                     vcode      <= nv;
                     pcode      <= np;
                     settle_cnt <= settle_len;
                     state      <= ST_SETTLE;
                  end
               end else begin
                  gate_cnt <= gate_cnt - 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/mscan_cnt.sv
module mscan_cnt #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          en,
   input  logic          hit,
   output logic [CW-1:0] sum
);
   localparam logic [CW-1:0] CMAX = {CW{1'b1}};

   logic [CW-1:0] acc;

   // running total including the current cycle, held at all-ones
   assign sum = (acc == CMAX) ? CMAX : acc + CW'(hit);

   always_ff @(posedge clk) begin
      if (!rst_n)   acc <= '0;
      else if (clr) acc <= '0;
      else if (en)  acc <= sum;
   end
endmodule

// File: rtl/mscan_store.sv
module mscan_store #(
   parameter int CW   = 8,
   parameter int NPOS = 24,
   parameter int IW   = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [IW-1:0] widx,
   input  logic [CW-1:0] wdata,
   input  logic [IW-1:0] ridx,
   output logic [CW-1:0] rdata
);
   logic [NPOS*CW-1:0] flat;

   for (genvar g = 0; g < NPOS; g++) begin : g_ent
      logic [CW-1:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n)                        q <= '0;
         else if (we && widx == IW'(g))     q <= wdata;
      end
      assign flat[g*CW +: CW] = q;
   end

   always_comb begin
      rdata = '0;
      if (int'(ridx) < NPOS) rdata = flat[int'(ridx)*CW +: CW];
   end
endmodule

// File: rtl/mscan_top.sv
module mscan_top
   import mscan_pkg::*;
#(
   parameter int VW = 4,
   parameter int PW = 3,
   parameter int CW = 8,
   parameter int GW = 8,
   parameter int SW = 4,
   localparam int NV   = 1 << VW,
   localparam int NP   = 1 << PW,
   localparam int NPOS = NV + NP,
   localparam int IW   = $clog2(NPOS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          main_bit,
   input  logic          scan_bit,
   input  logic [VW-1:0] ctr_vcode,
   input  logic [PW-1:0] ctr_pcode,
   input  logic [GW-1:0] gate_len,
   input  logic [SW-1:0] settle_len,
   input  logic [IW-1:0] rd_idx,
   output logic [VW-1:0] scan_vcode,
   output logic [PW-1:0] scan_pcode,
   output logic          busy,
   output logic          done,
   output logic [CW-1:0] rd_count
);
   if (VW < 1 || VW > 8) begin : g_bad_vw
      $error("mscan_top: VW must lie in 1..8");
   end
   if (PW < 1 || PW > 8) begin : g_bad_pw
      $error("mscan_top: PW must lie in 1..8");
   end
   if (CW < 1 || GW < 1 || SW < 1) begin : g_bad_w
      $error("mscan_top: CW, GW and SW must be at least 1");
   end

   mscan_st_e     state;
   logic [IW-1:0] pos;
   logic          last_gate;
   logic [CW-1:0] sum;

   mscan_seq #(
      .VW(VW), .PW(PW), .GW(GW), .SW(SW), .NV(NV), .NPOS(NPOS), .IW(IW)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .ctr_vcode  (ctr_vcode),
      .ctr_pcode  (ctr_pcode),
      .gate_len   (gate_len),
      .settle_len (settle_len),
      .state      (state),
      .pos        (pos),
      .last_gate  (last_gate),
      .vcode      (scan_vcode),
      .pcode      (scan_pcode),
      .done       (done)
   );

   mscan_cnt #(.CW(CW)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (state == ST_SETTLE),
      .en    (state == ST_GATE),
      .hit   (main_bit ^ scan_bit),
      .sum   (sum)
   );

   mscan_store #(.CW(CW), .NPOS(NPOS), .IW(IW)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (last_gate),
      .widx  (pos),
      .wdata (sum),
      .ridx  (rd_idx),
      .rdata (rd_count)
   );

   assign busy = (state != ST_IDLE);
endmodule

// File: rtl/mscan_chk.sv
module mscan_chk #(
   parameter int VW = 4,
   parameter int PW = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          busy,
   input logic          done,
   input logic [VW-1:0] scan_vcode,
   input logic [PW-1:0] scan_pcode
);
   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_busy_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   assert_start_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

   assert_vcode_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_vcode != $past(scan_vcode)) |-> busy);

   assert_pcode_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_pcode != $past(scan_pcode)) |-> busy);
endmodule

bind mscan_top mscan_chk #(.VW(VW), .PW(PW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .busy       (busy),
   .done       (done),
   .scan_vcode (scan_vcode),
   .scan_pcode (scan_pcode)
);

// File: tb/tb_mscan_top.sv
module tb_mscan_top;
   localparam int VW = 4, PW = 3, CW = 8, GW = 8, SW = 4;
   localparam int NV = 1 << VW, NP = 1 << PW, NPOS = NV + NP;
   localparam int IW = $clog2(NPOS);
   localparam int CMAX = (1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          main_bit = 1'b0, scan_bit = 1'b0;
   logic [VW-1:0] ctr_vcode = '0;
   logic [PW-1:0] ctr_pcode = '0;
   logic [GW-1:0] gate_len = '0;
   logic [SW-1:0] settle_len = '0;
   logic [IW-1:0] rd_idx = '0;
   logic [VW-1:0] scan_vcode;
   logic [PW-1:0] scan_pcode;
   logic          busy, done;
   logic [CW-1:0] rd_count;

   int checks = 0, errors = 0;
   int emode = 0;

   mscan_top #(.VW(VW), .PW(PW), .CW(CW), .GW(GW), .SW(SW)) dut (.*);

   always #4 clk = ~clk;

   task automatic check(string req, int act, int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // behavioural reference model
   int m_st = 0, m_sc = 0, m_gc = 0, m_pos = 0, m_acc = 0;
   int m_v = 0, m_p = 0, m_cv = 0, m_cp = 0, m_done = 0;
   int m_res [NPOS];

   task automatic place();
      if (m_pos < NV) begin m_v = m_pos; m_p = m_cp; end
      else begin m_v = m_cv; m_p = m_pos - NV; end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_sc = 0; m_gc = 0; m_pos = 0; m_acc = 0;
         m_v = 0; m_p = 0; m_cv = 0; m_cp = 0; m_done = 0;
         foreach (m_res[i]) m_res[i] = 0;
      end else begin
         m_done = 0;
         case (m_st)
            0: if (start) begin
               m_cv = int'(ctr_vcode); m_cp = int'(ctr_pcode);
               m_pos = 0; place(); m_sc = int'(settle_len); m_st = 1;
            end
            1: begin
               m_acc = 0;
               if (m_sc == 0) begin m_gc = int'(gate_len); m_st = 2; end
               else m_sc--;
            end
            default: begin
               if (main_bit != scan_bit) m_acc++;
               if (m_acc > CMAX) m_acc = CMAX;
               if (m_gc == 0) begin
                  m_res[m_pos] = m_acc;
                  if (m_pos == NPOS - 1) begin m_st = 0; m_done = 1; end
                  else begin m_pos++; place(); m_sc = int'(settle_len); m_st = 1; end
               end else m_gc--;
            end
         endcase
      end
   end

   // per-cycle comparison
   always @(negedge clk) begin
      if (rst_n) begin
         check("R2/R8/R9 busy", int'(busy), (m_st != 0) ? 1 : 0);
         check("R8 done", int'(done), m_done);
         check("R3/R4 scan_vcode", int'(scan_vcode), m_v);
         check("R3/R4 scan_pcode", int'(scan_pcode), m_p);
      end
   end

   // stimulus for the two data channels
   always @(negedge clk) begin
      int d, err;
      d = (int'(scan_vcode) > m_cv ? int'(scan_vcode) - m_cv : m_cv - int'(scan_vcode))
        + (int'(scan_pcode) > m_cp ? int'(scan_pcode) - m_cp : m_cp - int'(scan_pcode));
      case (emode)
         0: err = 0;
         1: err = 1;
         2: err = int'($urandom % 2);
         default: err = (int'($urandom % 16) < d) ? 1 : 0;
      endcase
      main_bit <= 1'($urandom % 2);
      scan_bit <= 1'($urandom % 2);
      #1 scan_bit <= main_bit ^ 1'(err);
   end

   task automatic read_all(string req);
      for (int i = 0; i < NPOS; i++) begin
         rd_idx = IW'(i);
         #1 check(req, int'(rd_count), m_res[i]);
      end
   endtask

   task automatic run_scan(int cv, int cp, int gl, int sl, int mode, int extra);
      @(negedge clk);
      emode = mode;
      ctr_vcode = VW'(cv); ctr_pcode = PW'(cp);
      gate_len = GW'(gl); settle_len = SW'(sl);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (extra == 1) begin
         // a request during the scan with different centre codes
         repeat (40) @(negedge clk);
         ctr_vcode = VW'(2); ctr_pcode = PW'(1); start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      if (extra == 2) begin
         // hold start across the final gate cycle and the done cycle
         while (!(m_st == 2 && m_pos == NPOS - 1 && m_gc == 0)) @(negedge clk);
         ctr_vcode = VW'(12); ctr_pcode = PW'(6); start = 1'b1;
         @(negedge clk);
         check("R8 done while start held", int'(done), 1);
         read_all("R7/R8 results in done cycle");
         @(negedge clk);
         start = 1'b0;
         check("R9 restart from done cycle", int'(busy), 1);
         check("R2 restart voltage code", int'(scan_vcode), 0);
         check("R2 restart phase code", int'(scan_pcode), 6);
      end
      while (!done) @(negedge clk);
      read_all("R5/R6/R7 result");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 busy at reset", int'(busy), 0);
      check("R1 done at reset", int'(done), 0);
      check("R1 vcode at reset", int'(scan_vcode), 0);
      check("R1 pcode at reset", int'(scan_pcode), 0);
      check("R1 result at reset", int'(rd_count), 0);
      rst_n = 1'b1;
      @(negedge clk);
      rd_idx = IW'(NPOS - 1);
      #1 check("R1 last result after reset", int'(rd_count), 0);

      run_scan(7, 3, 3, 2, 1, 0);
      rd_idx = '0;
      #1 check("R5 window of four all differing", int'(rd_count), 4);
      rd_idx = IW'(30);
      #1 check("R7 out-of-range index", int'(rd_count), 0);

      run_scan(5, 2, 6, 0, 0, 0);
      rd_idx = IW'(10);
      #1 check("R5/R7 agreeing channels overwrite", int'(rd_count), 0);

      run_scan(9, 4, 20, 0, 3, 1);
      repeat (5) @(negedge clk);
      check("R9 no restart after ignored start", int'(busy), 0);
      read_all("R7 results retained");

      run_scan(3, 5, 9, 15, 2, 2);
      run_scan(8, 0, 254, 1, 1, 0);
      rd_idx = IW'(20);
      #1 check("R6 count at ceiling", int'(rd_count), CMAX);
      run_scan(8, 7, 255, 1, 1, 0);
      rd_idx = '0;
      #1 check("R6 saturation without wrap", int'(rd_count), CMAX);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule